// File: doc/BRIEF.md
# Vector Lane Multiply-Accumulate Unit

This block is a four-lane SIMD datapath for 16-bit fixed-point words, with a small vector register file. Each operation reads two source registers. Every lane multiplies its own element of the first source by either its own element of the second source or one broadcast element of that source. The 32-bit product is then loaded into, or added to, that lane's private accumulator. A signed post-shift scales the value, and a 16-bit result is written back to a destination register in all lanes at once.

Software-visible data moves through whole-vector ports. The load port writes one register in a single cycle, and the store port reads any register combinationally. Register 0 is hardwired to zero and register 1 is hardwired to one in every lane. A load aimed at register 0 is refused and reported. Each operation is started by a one-cycle strobe. Its result is in the register file, and the done pulse is high, in the cycle after the strobe.

Two precision modes exist. Single precision accumulates raw products and shifts on the way out, with round-half-up applied only for a plain multiply at a shift of -15. Double precision shifts the product before it enters the accumulator, and writes out only the 15-bit fraction of the accumulator.

Top module: `vec_mac_unit`

## Requirements
- R1: All four lanes execute the same operation in the same cycle, and each lane updates only its own 32-bit accumulator. Lane i occupies bits [16i+15:16i] of every vector port.
- R2: After a synchronous reset, registers 0 and 2..7 read zero in all lanes, register 1 reads 1 in all lanes, every accumulator is zero, and op_done and ld_err are low.
- R3: A load with ld_addr = 0 leaves register 0 reading zero and raises ld_err for exactly the next cycle. A load with ld_addr = 1 is ignored without error. Any other load leaves ld_err low.
- R4: A load with ld_en high writes all four lanes of register ld_addr (2..7) at the clock edge. st_data always shows register st_addr.
- R5: op_shift is 6-bit two's complement. A value n >= 0 shifts the 32-bit value left by n, and a value n < 0 shifts it arithmetically right by -n. A single-precision result keeps the low 16 bits of the shifted value.
- R6: A single-precision multiply (op_accum = 0, op_dbl = 0) loads the raw product into the accumulator. When op_shift = -15, 2^14 is added before the shift; no other shift rounds.
- R7: A single-precision multiply-accumulate (op_accum = 1, op_dbl = 0) adds the raw product to the accumulator, never rounds, and writes the shifted accumulator.
- R8: In double precision (op_dbl = 1), the shifted product is loaded into (op_accum = 0) or added to (op_accum = 1) the accumulator. The result is accumulator bits [14:0] with bit 15 zero.
- R9: With op_scalar = 1, the second operand of every lane is lane op_elem of register op_src_t.
- R10: op_done is high exactly in the cycle after an op_start cycle. In that cycle the destination register already holds the result.
- R11: An operation whose destination is register 0 or 1 updates the accumulators, but the register still reads 0 or 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Vector load strobe |
| ld_addr | input | 3 | Load destination register |
| ld_data | input | 64 | Load data, four lanes |
| ld_err | output | 1 | Pulse: load to register 0 refused |
| st_addr | input | 3 | Store read register |
| st_data | output | 64 | Store read data, four lanes |
| op_start | input | 1 | Operation strobe |
| op_accum | input | 1 | 0 multiply, 1 multiply-accumulate |
| op_dbl | input | 1 | Double-precision mode |
| op_scalar | input | 1 | Broadcast one element of the second source |
| op_elem | input | 2 | Broadcast element index |
| op_shift | input | 6 | Signed post-shift amount |
| op_src_s | input | 3 | First source register |
| op_src_t | input | 3 | Second source register |
| op_dst | input | 3 | Destination register |
| op_done | output | 1 | Result written (one cycle after start) |

## Verification
Four properties are checked on every cycle. op_done follows op_start with a latency of exactly one cycle. ld_err rises only after a refused load to register 0. Accumulators hold their value in cycles without an operation and are zero in the first cycle after reset. Stored registers hold their value when neither write port is active. The arithmetic itself can only be shown by the bench scenarios, which compare results with a reference model: rounding at the one special shift, left and right shifts with truncation, accumulation across operations, the double-precision fraction mask, scalar broadcast, and writes to the hardwired registers.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    parameter int LANES = 4;
    parameter int WORD  = 16;
    parameter int ACCW  = 32;
    parameter int NREGS = 8;
    parameter int SHW   = 6;

    localparam int RAW  = $clog2(NREGS);
    localparam int ELW  = $clog2(LANES);
    localparam int VECW = LANES * WORD;
    localparam int FIRST_FREE = 2;

    typedef logic signed [WORD-1:0] word_t;
    typedef logic signed [ACCW-1:0] acc_t;
    typedef logic [RAW-1:0]         raddr_t;
    typedef logic signed [SHW-1:0]  shamt_t;
    typedef logic [VECW-1:0]        vec_t;

    typedef struct packed {
        logic           accum;
        logic           dbl;
        logic           scalar;
        logic [ELW-1:0] elem;
        shamt_t         shift;
        raddr_t         src_s;
        raddr_t         src_t;
        raddr_t         dst;
    } op_t;

    localparam shamt_t ROUND_SHIFT = shamt_t'(-(WORD - 1));
    localparam acc_t   ROUND_BIAS  = acc_t'(1) <<< (WORD - 2);

    // Positive amount: left shift. Negative: arithmetic right by magnitude.
    function automatic acc_t post_shift(acc_t v, shamt_t sh);
        logic [SHW:0] mag;
        mag = '0;
        if (!sh[SHW-1]) begin
            return v <<< sh[SHW-2:0];
        end
        mag = -{sh[SHW-1], sh};
        return v >>> mag;
    endfunction
endpackage

// File: rtl/vmac_regfile.sv
module vmac_regfile
    import vmac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld_we,
    input  raddr_t ld_addr,
    input  vec_t   ld_data,
    output logic   ld_err,
    input  logic   wr_we,
    input  raddr_t wr_addr,
    input  vec_t   wr_data,
    input  raddr_t ra_s,
    input  raddr_t ra_t,
    input  raddr_t ra_st,
    output vec_t   rd_s,
    output vec_t   rd_t,
    output vec_t   rd_st
);
    localparam raddr_t ZERO_REG = raddr_t'(0);
    localparam raddr_t ONE_REG  = raddr_t'(1);
    localparam int NPORTS = 3;

    vec_t mem [NREGS-1:FIRST_FREE];
    vec_t one_vec;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            one_vec[l*WORD +: WORD] = WORD'(1);
        end
    end

    // Stored registers; an operation write wins over a load to the same register.
    for (genvar r = FIRST_FREE; r < NREGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[r] <= '0;
            end else if (wr_we && wr_addr == raddr_t'(r)) begin
                mem[r] <= wr_data;
            end else if (ld_we && ld_addr == raddr_t'(r)) begin
                mem[r] <= ld_data;
            end
        end

        assert property (@(posedge clk) disable iff (rst)
            !(wr_we && wr_addr == raddr_t'(r)) && !(ld_we && ld_addr == raddr_t'(r))
            |=> $stable(mem[r]))
            else $error("assert_reg_hold_R4");
    end

    always_ff @(posedge clk) begin
        if (rst) ld_err <= 1'b0;
        else     ld_err <= ld_we && (ld_addr == ZERO_REG);
    end

    raddr_t ra [NPORTS];
    vec_t   rd [NPORTS];
    assign ra[0] = ra_s;
    assign ra[1] = ra_t;
    assign ra[2] = ra_st;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        always_comb begin
            if (ra[p] == ZERO_REG)     rd[p] = '0;
            else if (ra[p] == ONE_REG) rd[p] = one_vec;
            else                       rd[p] = mem[ra[p]];
        end
    end

    assign rd_s  = rd[0];
    assign rd_t  = rd[1];
    assign rd_st = rd[2];

    assert property (@(posedge clk) disable iff (rst)
        ld_we && ld_addr == ZERO_REG |=> ld_err)
        else $error("assert_load_err_R3");

    assert property (@(posedge clk) disable iff (rst)
        ld_err |-> $past(ld_we && ld_addr == ZERO_REG))
        else $error("assert_err_cause_R3");
endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
    import vmac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   accum,
    input  logic   dbl,
    input  shamt_t shift,
    input  word_t  opa,
    input  word_t  opb,
    output word_t  res
);
    acc_t acc_q;
    acc_t acc_n;
    acc_t prod;
    acc_t base;
    acc_t shifted;

    always_comb begin
        prod    = acc_t'(opa) * acc_t'(opb);
        base    = accum ? acc_q : '0;
        shifted = '0;
        if (dbl) begin
            acc_n = base + post_shift(prod, shift);
            res   = {1'b0, acc_n[WORD-2:0]};
        end else begin
            acc_n = base + prod;
            if (!accum && shift == ROUND_SHIFT) acc_n = acc_n + ROUND_BIAS;
            shifted = post_shift(acc_n, shift);
            res     = shifted[WORD-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        acc_q <= '0;
        else if (start) acc_q <= acc_n;
    end

    assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(acc_q))
        else $error("assert_acc_hold_R1");

    assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> acc_q == '0)
        else $error("assert_acc_reset_R2");
endmodule

// File: rtl/vec_mac_unit.sv
module vec_mac_unit
    import vmac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_en,
    input  logic [RAW-1:0]           ld_addr,
    input  logic [VECW-1:0]          ld_data,
    output logic                     ld_err,
    input  logic [RAW-1:0]           st_addr,
    output logic [VECW-1:0]          st_data,
    input  logic                     op_start,
    input  logic                     op_accum,
    input  logic                     op_dbl,
    input  logic                     op_scalar,
    input  logic [ELW-1:0]           op_elem,
    input  logic [SHW-1:0]           op_shift,
    input  logic [RAW-1:0]           op_src_s,
    input  logic [RAW-1:0]           op_src_t,
    input  logic [RAW-1:0]           op_dst,
    output logic                     op_done
);
    op_t  op;
    vec_t vs;
    vec_t vt;
    vec_t result;

    always_comb begin
        op.accum  = op_accum;
        op.dbl    = op_dbl;
        op.scalar = op_scalar;
        op.elem   = op_elem;
        op.shift  = shamt_t'(op_shift);
        op.src_s  = op_src_s;
        op.src_t  = op_src_t;
        op.dst    = op_dst;
    end

    vmac_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ld_we   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .ld_err  (ld_err),
        .wr_we   (op_start),
        .wr_addr (op.dst),
        .wr_data (result),
        .ra_s    (op.src_s),
        .ra_t    (op.src_t),
        .ra_st   (st_addr),
        .rd_s    (vs),
        .rd_t    (vt),
        .rd_st   (st_data)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        word_t opa;
        word_t opb;
        word_t res;

        assign opa = vs[i*WORD +: WORD];
        assign opb = op.scalar ? vt[op.elem*WORD +: WORD] : vt[i*WORD +: WORD];
        assign result[i*WORD +: WORD] = res;

        vmac_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .start (op_start),
            .accum (op.accum),
            .dbl   (op.dbl),
            .shift (op.shift),
            .opa   (opa),
            .opb   (opb),
            .res   (res)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) op_done <= 1'b0;
        else     op_done <= op_start;
    end

    assert property (@(posedge clk) disable iff (rst)
        op_start |=> op_done)
        else $error("assert_done_follow_R10");

    assert property (@(posedge clk) disable iff (rst)
        op_done |-> $past(op_start))
        else $error("assert_done_cause_R10");
endmodule

// File: tb/tb_vec_mac_unit.sv
module tb_vec_mac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [2:0]  ld_addr;
    logic [63:0] ld_data;
    logic        ld_err;
    logic [2:0]  st_addr;
    logic [63:0] st_data;
    logic        op_start, op_accum, op_dbl, op_scalar;
    logic [1:0]  op_elem;
    logic [5:0]  op_shift;
    logic [2:0]  op_src_s, op_src_t, op_dst;
    logic        op_done;

    always #4 clk = ~clk;

    vec_mac_unit dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .ld_err(ld_err), .st_addr(st_addr), .st_data(st_data), .op_start(op_start),
        .op_accum(op_accum), .op_dbl(op_dbl), .op_scalar(op_scalar), .op_elem(op_elem),
        .op_shift(op_shift), .op_src_s(op_src_s), .op_src_t(op_src_t), .op_dst(op_dst),
        .op_done(op_done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic signed [15:0] m_reg [8][4];
    logic signed [31:0] m_acc [4];

    typedef struct {
        logic [2:0]  dst;
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [15:0] m_rd(int r, int l);
        if (r == 0) return 16'sd0;
        if (r == 1) return 16'sd1;
        return m_reg[r][l];
    endfunction

    function automatic logic [63:0] m_vec(int r);
        logic [63:0] v;
        for (int l = 0; l < 4; l++) v[l*16 +: 16] = m_rd(r, l);
        return v;
    endfunction

    function automatic logic signed [31:0] sh32(logic signed [31:0] v, int s);
        if (s >= 0) return v <<< s;
        return v >>> (-s);
    endfunction

    function automatic logic [63:0] pack4(int a0, int a1, int a2, int a3);
        return {a3[15:0], a2[15:0], a1[15:0], a0[15:0]};
    endfunction

    task automatic read_vec(int r, output logic [63:0] v);
        st_addr = 3'(r);
        #1;
        v = st_data;
    endtask

    task automatic load(int r, logic [63:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 3'(r); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        if (r >= 2) for (int l = 0; l < 4; l++) m_reg[r][l] = v[l*16 +: 16];
    endtask

    // Driver: model the requirements, queue the expected vector, strobe the op.
    task automatic issue(bit acc, bit dbl, bit scal, int el, int sh, int s, int t, int d, string tag);
        logic signed [15:0] res [4];
        item_t it;
        for (int l = 0; l < 4; l++) begin
            logic signed [31:0] a, b, prod, base, na;
            a = m_rd(s, l);
            b = scal ? m_rd(t, el) : m_rd(t, l);
            prod = a * b;
            base = acc ? m_acc[l] : 32'sd0;
            if (dbl) begin
                na = base + sh32(prod, sh);
                res[l] = {1'b0, na[14:0]};
            end else begin
                na = base + prod + ((!acc && sh == -15) ? 32'sd16384 : 32'sd0);
                res[l] = 16'(sh32(na, sh));
            end
            m_acc[l] = na;
        end
        if (d >= 2) for (int l = 0; l < 4; l++) m_reg[d][l] = res[l];
        it.dst = 3'(d); it.exp = m_vec(d); it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        op_start = 1'b1; op_accum = acc; op_dbl = dbl; op_scalar = scal;
        op_elem = 2'(el); op_shift = 6'(sh);
        op_src_s = 3'(s); op_src_t = 3'(t); op_dst = 3'(d);
        @(negedge clk);
        op_start = 1'b0;
        wait (sbq.size() == 0);
    endtask

    // Monitor: on each done cycle pop the oldest expectation and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && op_done) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 64'(op_done), 64'd0);
                end else begin
                    item_t it;
                    logic [63:0] v;
                    it = sbq.pop_front();
                    read_vec(it.dst, v);
                    check(v == it.exp, it.tag, v, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        rst = 1'b1; ld_en = 0; ld_addr = 0; ld_data = 0; st_addr = 0;
        op_start = 0; op_accum = 0; op_dbl = 0; op_scalar = 0; op_elem = 0;
        op_shift = 0; op_src_s = 0; op_src_t = 0; op_dst = 0;
        for (int r = 0; r < 8; r++) for (int l = 0; l < 4; l++) m_reg[r][l] = 0;
        for (int l = 0; l < 4; l++) m_acc[l] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        for (int r = 0; r < 8; r++) begin
            read_vec(r, v);
            check(v == m_vec(r), "R2 reset register", v, m_vec(r));
        end
        check(!op_done && !ld_err, "R2 reset flags", {ld_err, op_done}, 64'd0);

        // R4: whole-vector load and store
        load(2, pack4(4, -3, 7, 100));
        load(3, pack4(5, 6, -2, 300));
        read_vec(2, v);
        check(v == pack4(4, -3, 7, 100), "R4 load/store r2", v, pack4(4, -3, 7, 100));
        read_vec(3, v);
        check(v == pack4(5, 6, -2, 300), "R4 load/store r3", v, pack4(5, 6, -2, 300));
        check(!ld_err, "R3 no error on normal load", 64'(ld_err), 64'd0);

        // R3: refused load to register 0, ignored load to register 1
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 3'd0; ld_data = '1;
        @(negedge clk);
        ld_en = 1'b0;
        check(ld_err, "R3 error pulse", 64'(ld_err), 64'd1);
        @(negedge clk);
        check(!ld_err, "R3 error is one cycle", 64'(ld_err), 64'd0);
        read_vec(0, v);
        check(v == 64'd0, "R3 r0 still zero", v, 64'd0);
        load(1, pack4(9, 9, 9, 9));
        read_vec(1, v);
        check(v == m_vec(1), "R3 r1 still one", v, m_vec(1));
        check(!ld_err, "R3 no error for r1", 64'(ld_err), 64'd0);

        // R1 R6 R10: per-lane multiply, shift 0
        issue(0, 0, 0, 0, 0, 2, 3, 4, "R1 R6 R10 lane multiply");
        // R5: left shift, arithmetic right shift, truncation
        issue(0, 0, 0, 0, 2, 2, 3, 5, "R5 left shift");
        issue(0, 0, 0, 0, -3, 2, 3, 5, "R5 arithmetic right shift");
        load(6, pack4(16'h7fff, -32768, 1000, 255));
        issue(0, 0, 0, 0, 0, 6, 6, 7, "R5 truncation to 16 bits");
        // R6: round-half-up only at -15
        load(6, pack4(16'h4000, 16'hc000, 16'h6000, 16'h2000));
        issue(0, 0, 0, 0, -15, 6, 1, 7, "R6 rounding at -15");
        issue(0, 0, 0, 0, -14, 6, 1, 7, "R6 no rounding at -14");
        // R7: accumulate, no rounding on multiply-accumulate
        issue(0, 0, 0, 0, 0, 6, 1, 7, "R7 preload");
        issue(1, 0, 0, 0, -15, 6, 0, 7, "R7 mac at -15 does not round");
        issue(0, 0, 0, 0, 0, 2, 3, 4, "R7 start");
        issue(1, 0, 0, 0, 0, 2, 3, 4, "R7 accumulate twice");
        // R8: double precision mask and pre-shift
        load(6, pack4(16'h00ff, -255, 16'h7fff, 3));
        load(7, pack4(16'h0100, 16'h0100, 16'h7fff, 5));
        issue(0, 1, 0, 0, 0, 6, 7, 5, "R8 double fraction mask");
        issue(1, 1, 0, 0, -1, 6, 7, 5, "R8 double accumulate shifted");
        // R9: scalar broadcast
        issue(0, 0, 1, 2, 0, 2, 3, 4, "R9 scalar element 2");
        issue(0, 0, 1, 3, 0, 3, 3, 4, "R9 scalar element 3");
        // R11: destinations 0 and 1 stay hardwired
        issue(0, 0, 0, 0, 0, 2, 3, 0, "R11 dst r0");
        issue(0, 0, 0, 0, 0, 2, 3, 1, "R11 dst r1");
        issue(1, 0, 0, 0, 0, 1, 1, 4, "R11 accumulator still updated");

        // R1: mixed operations
        for (int k = 0; k < 40; k++) begin
            int sh;
            sh = int'($urandom_range(30)) - 15;
            if (k % 8 == 0) load(2 + k % 6, {$urandom, $urandom});
            issue($urandom_range(1), $urandom_range(1), $urandom_range(1),
                  $urandom_range(3), sh, $urandom_range(7), $urandom_range(7),
                  2 + $urandom_range(5), "R1 mixed sequence");
        end

        @(negedge clk);
        check(!op_done, "R10 done single cycle", 64'(op_done), 64'd0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule